// File: doc/BRIEF.md
# Post-modify load address unit

This block forms the effective address of a load and, for the modes that update a pointer, the pointer's next value. It sits beside the register file of a load pipeline. Each cycle it takes a 3-bit mode, an access size of one or two bytes, the register operands and the immediates. One clock later it presents the address, the new pointer and a write-back enable. Memory access and data handling belong to other blocks.

The eight modes fall into two groups. The first group has no pointer update: base plus a scaled offset, and a shifted index plus an absolute value. The second group writes a pointer back: absolute with pointer set, post-increment by the modifier register, bit-reversed post-increment, post-increment by a scaled immediate, and two circular modes. In the circular modes the pointer stays inside a buffer. The buffer starts at a separate start register, and its length is taken from the low field of the modifier.

Top module: `load_agu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first evaluation, `ea_q`, `ptr_new_q` and `wb_en_q` are all zero.
- R2: Mode 0 (base offset): `ea_q` = `base_reg` + sign-extended 11-bit `imm_ofs`, shifted left by `size_half`. `wb_en_q` is 0 and `ptr_new_q` echoes `ptr_reg`.
- R3: Mode 1 (indexed absolute): `ea_q` = (`index_reg` << `idx_shift`) + `abs_addr`. `wb_en_q` is 0.
- R4: Mode 2 (absolute set): `ea_q` and `ptr_new_q` both equal `abs_addr`, and `wb_en_q` is 1.
- R5: Mode 3 (register post-increment): `ea_q` = `ptr_reg` and `ptr_new_q` = `ptr_reg` + `mod_reg`, with a two's complement wrap at 32 bits.
- R6: Mode 4 (bit-reversed): `ea_q` keeps `ptr_reg[31:16]` and holds the bit-reversal of `ptr_reg[15:0]` in its low 16 bits. `ptr_new_q` = `ptr_reg` + `mod_reg`. With a 64 KiB-aligned start and a modifier of 0x2000, successive addresses fall at offsets 0, 4, 2, 6.
- R7: Mode 5 (immediate post-increment): `ea_q` = `ptr_reg` and `ptr_new_q` = `ptr_reg` + sign-extended 4-bit `imm_inc`, shifted left by `size_half`.
- R8: Mode 6 (circular immediate): `ea_q` = `ptr_reg`. The step is the scaled `imm_inc`, and the length L is `mod_reg[16:0]`. If the stepped pointer is at or beyond `circ_start`+L, L is subtracted. If it is below `circ_start`, L is added.
- R9: Mode 7 (circular register): same as R8, but the step is the signed 7-bit field `mod_reg[23:17]`, shifted left by `size_half`.
- R10: `wb_en_q` is 1 exactly for modes 2 to 7.
- R11: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge: one cycle of latency, and a new operation every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Addressing mode, 0 to 7 as in R2 to R9 |
| size_half | input | 1 | 0 = byte access, 1 = half-word access (scale by 2) |
| base_reg | input | 32 | Base for mode 0 |
| index_reg | input | 32 | Index for mode 1 |
| idx_shift | input | 2 | Left shift applied to the index |
| abs_addr | input | 32 | Absolute value for modes 1 and 2 |
| ptr_reg | input | 32 | Current pointer for modes 3 to 7 |
| mod_reg | input | 32 | Modifier: step, or increment and length fields |
| circ_start | input | 32 | Circular buffer start |
| imm_ofs | input | 11 | Signed offset for mode 0 |
| imm_inc | input | 4 | Signed step for modes 5 and 6 |
| ea_q | output | 32 | Effective address |
| ptr_new_q | output | 32 | Updated pointer value |
| wb_en_q | output | 1 | Pointer write-back enable |

## Verification
Offsets are tried both positive and negative, and at both access sizes, so that a missing sign extension or a missing size scale shows as a different address. The post-increment, bit-reversed and circular modes are run as chains, with each new pointer fed back as the next pointer. This separates a correct bit-reversal order (0, 4, 2, 6) from a plain increment, and it exercises the circular wrap at the top of the buffer, at the bottom when stepping backwards, and at exact multiples of the length. The register-held circular increment is driven with a negative field value to show that it is treated as signed.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [2:0] {
        AM_BASE_OFS  = 3'd0,
        AM_IDX_ABS   = 3'd1,
        AM_ABS_SET   = 3'd2,
        AM_POST_REG  = 3'd3,
        AM_POST_BREV = 3'd4,
        AM_POST_IMM  = 3'd5,
        AM_CIRC_IMM  = 3'd6,
        AM_CIRC_REG  = 3'd7
    } amode_e;
endpackage

// File: rtl/agu_scale.sv
// Sign-extends a narrow immediate and scales it by the access size.
module agu_scale #(
    parameter int AW = 32,
    parameter int IW = 4
) (
    input  logic [IW-1:0] imm,
    input  logic          size_half,
    output logic [AW-1:0] scaled
);
    localparam int EXT_W = AW - IW;
    logic [AW-1:0] ext;
    always_comb begin
        ext    = {{EXT_W{imm[IW-1]}}, imm};
        scaled = size_half ? {ext[AW-2:0], 1'b0} : ext;
    end
endmodule

// File: rtl/agu_bitrev.sv
// Keeps the upper bits and mirrors the low REV_W bits of a pointer.
module agu_bitrev #(
    parameter int AW    = 32,
    parameter int REV_W = 16
) (
    input  logic [AW-1:0] ptr,
    output logic [AW-1:0] addr
);
    for (genvar i = 0; i < REV_W; i++) begin : g_rev
        assign addr[i] = ptr[REV_W-1-i];
    end
    assign addr[AW-1:REV_W] = ptr[AW-1:REV_W];
endmodule

// File: rtl/agu_circ.sv
// Steps a pointer and folds it back into [start, start+len).
module agu_circ #(
    parameter int AW    = 32,
    parameter int LEN_W = 17
) (
    input  logic [AW-1:0]    ptr,
    input  logic [AW-1:0]    step,
    input  logic [AW-1:0]    start,
    input  logic [LEN_W-1:0] len,
    output logic [AW-1:0]    next
);
    localparam int PAD_W = AW - LEN_W;
    logic [AW-1:0] len_ext;
    logic [AW-1:0] limit;
    logic [AW-1:0] sum;
    always_comb begin
        len_ext = {{PAD_W{1'b0}}, len};
        limit   = start + len_ext;
        sum     = ptr + step;
        if (sum >= limit) begin
            next = sum - len_ext;
        end else if (sum < start) begin
            next = sum + len_ext;
        end else begin
            next = sum;
        end
    end
endmodule

// File: rtl/load_agu.sv
module load_agu
    import agu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int OFS_W = 11,
    parameter int INC_W = 4,
    parameter int MIN_W = 7,
    parameter int LEN_W = 17,
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             size_half,
    input  logic [AW-1:0]    base_reg,
    input  logic [AW-1:0]    index_reg,
    input  logic [1:0]       idx_shift,
    input  logic [AW-1:0]    abs_addr,
    input  logic [AW-1:0]    ptr_reg,
    input  logic [AW-1:0]    mod_reg,
    input  logic [AW-1:0]    circ_start,
    input  logic [OFS_W-1:0] imm_ofs,
    input  logic [INC_W-1:0] imm_inc,
    output logic [AW-1:0]    ea_q,
    output logic [AW-1:0]    ptr_new_q,
    output logic             wb_en_q
);
    localparam int MIN_LO = LEN_W;
    localparam int MIN_HI = LEN_W + MIN_W - 1;

    typedef struct packed {
        logic [AW-1:0] ea;
        logic [AW-1:0] ptr;
        logic          wb;
    } agu_out_t;

    agu_out_t out_d, out_q;
    amode_e   am;

    logic [AW-1:0]    ofs_sc, inc_sc, minc_sc;
    logic [AW-1:0]    brev_ea, circ_imm_nxt, circ_reg_nxt;
    logic [MIN_W-1:0] minc_fld;
    logic [LEN_W-1:0] len_fld;

    assign minc_fld = mod_reg[MIN_HI:MIN_LO];
    assign len_fld  = mod_reg[LEN_W-1:0];

    agu_scale #(.AW(AW), .IW(OFS_W)) u_sc_ofs (.imm(imm_ofs),  .size_half(size_half), .scaled(ofs_sc));
    agu_scale #(.AW(AW), .IW(INC_W)) u_sc_inc (.imm(imm_inc),  .size_half(size_half), .scaled(inc_sc));
    agu_scale #(.AW(AW), .IW(MIN_W)) u_sc_min (.imm(minc_fld), .size_half(size_half), .scaled(minc_sc));

    agu_bitrev #(.AW(AW), .REV_W(REV_W)) u_brev (.ptr(ptr_reg), .addr(brev_ea));

    agu_circ #(.AW(AW), .LEN_W(LEN_W)) u_circ_imm (
        .ptr(ptr_reg), .step(inc_sc), .start(circ_start), .len(len_fld), .next(circ_imm_nxt)
    );
    agu_circ #(.AW(AW), .LEN_W(LEN_W)) u_circ_reg (
        .ptr(ptr_reg), .step(minc_sc), .start(circ_start), .len(len_fld), .next(circ_reg_nxt)
    );

    always_comb begin
        am        = amode_e'(mode);
        out_d.ea  = ptr_reg;
        out_d.ptr = ptr_reg;
        out_d.wb  = 1'b1;
        case (am)
            AM_BASE_OFS: begin
                out_d.ea = base_reg + ofs_sc;
                out_d.wb = 1'b0;
            end
            AM_IDX_ABS: begin
                out_d.ea = (index_reg << idx_shift) + abs_addr;
                out_d.wb = 1'b0;
            end
            AM_ABS_SET: begin
                out_d.ea  = abs_addr;
                out_d.ptr = abs_addr;
            end
            AM_POST_REG:  out_d.ptr = ptr_reg + mod_reg;
            AM_POST_BREV: begin
                out_d.ea  = brev_ea;
                out_d.ptr = ptr_reg + mod_reg;
            end
            AM_POST_IMM:  out_d.ptr = ptr_reg + inc_sc;
            AM_CIRC_IMM:  out_d.ptr = circ_imm_nxt;
            AM_CIRC_REG:  out_d.ptr = circ_reg_nxt;
            default:      out_d.wb  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ea_q      = out_q.ea;
    assign ptr_new_q = out_q.ptr;
    assign wb_en_q   = out_q.wb;
endmodule

// File: rtl/load_agu_chk.sv
module load_agu_chk #(
    parameter int AW    = 32,
    parameter int OFS_W = 11,
    parameter int INC_W = 4,
    parameter int LEN_W = 17,
    parameter int REV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic [AW-1:0]    ptr_reg,
    input logic [AW-1:0]    mod_reg,
    input logic [AW-1:0]    abs_addr,
    input logic [AW-1:0]    circ_start,
    input logic [AW-1:0]    ea_q,
    input logic [AW-1:0]    ptr_new_q,
    input logic             wb_en_q
);
    localparam logic [LEN_W-1:0] SAFE_LEN = LEN_W'(16);
    logic [AW-1:0] len_now;
    assign len_now = {{(AW-LEN_W){1'b0}}, mod_reg[LEN_W-1:0]};

    // R10: pointer-updating modes raise the write-back enable
    assert_wb_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 3'd2) |=> wb_en_q);
    // R10: the address-only modes leave it low
    assert_wb_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode < 3'd2) |=> !wb_en_q);
    // R4: absolute set gives the same address and pointer
    assert_abs_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |=> (ea_q == $past(abs_addr)) && (ptr_new_q == ea_q));
    // R5 R7 R8 R9: post modes address through the old pointer
    assert_post_ea_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 || mode >= 3'd5) |=> ea_q == $past(ptr_reg));
    // R6: bit reversal leaves the upper half untouched
    assert_brev_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |=> ea_q[AW-1:REV_W] == $past(ptr_reg[AW-1:REV_W]));
    // R8: with a buffer longer than any immediate step, the pointer stays inside
    assert_circ_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && mod_reg[LEN_W-1:0] > SAFE_LEN && ptr_reg >= circ_start
         && ptr_reg < circ_start + len_now)
        |=> (ptr_new_q >= $past(circ_start)) && (ptr_new_q < $past(circ_start) + $past(len_now)));
endmodule

bind load_agu load_agu_chk #(.AW(AW), .OFS_W(OFS_W), .INC_W(INC_W), .LEN_W(LEN_W), .REV_W(REV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ptr_reg(ptr_reg), .mod_reg(mod_reg),
    .abs_addr(abs_addr), .circ_start(circ_start), .ea_q(ea_q), .ptr_new_q(ptr_new_q),
    .wb_en_q(wb_en_q)
);

// File: tb/sim_load_agu.sv
`timescale 1ns/1ps
module sim_load_agu;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  mode;
    logic        size_half;
    logic [31:0] base_reg, index_reg, abs_addr, ptr_reg, mod_reg, circ_start;
    logic [1:0]  idx_shift;
    logic [10:0] imm_ofs;
    logic [3:0]  imm_inc;
    logic [31:0] ea_q, ptr_new_q;
    logic        wb_en_q;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    load_agu u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .size_half(size_half),
        .base_reg(base_reg), .index_reg(index_reg), .idx_shift(idx_shift),
        .abs_addr(abs_addr), .ptr_reg(ptr_reg), .mod_reg(mod_reg),
        .circ_start(circ_start), .imm_ofs(imm_ofs), .imm_inc(imm_inc),
        .ea_q(ea_q), .ptr_new_q(ptr_new_q), .wb_en_q(wb_en_q)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    // drive at negedge, result visible just after the following posedge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic op(input logic [2:0] m, input logic h);
        @(negedge clk);
        mode = m;
        size_half = h;
        step();
    endtask

    task automatic test_reset();
        chk("R1", "ea", ea_q, 32'h0);
        chk("R1", "ptr", ptr_new_q, 32'h0);
        chk("R1", "wb", {31'd0, wb_en_q}, 32'h0);
    endtask

    task automatic test_base_ofs();
        base_reg = 32'h0000_1000;
        ptr_reg  = 32'h0000_0777;
        imm_ofs  = 11'h7FD;
        op(3'd0, 1'b1);
        chk("R2", "neg half ea", ea_q, 32'h0000_0FFA);
        chk("R2", "ptr echo", ptr_new_q, 32'h0000_0777);
        chk("R10", "wb base", {31'd0, wb_en_q}, 32'h0);
        imm_ofs = 11'h3FF;
        op(3'd0, 1'b0);
        chk("R2", "max byte ea", ea_q, 32'h0000_13FF);
    endtask

    task automatic test_idx_abs();
        index_reg = 32'd3;
        idx_shift = 2'd1;
        abs_addr  = 32'h0000_2000;
        op(3'd1, 1'b0);
        chk("R3", "idx<<1", ea_q, 32'h0000_2006);
        chk("R10", "wb idx", {31'd0, wb_en_q}, 32'h0);
        index_reg = 32'd5;
        idx_shift = 2'd3;
        op(3'd1, 1'b1);
        chk("R3", "idx<<3", ea_q, 32'h0000_2028);
    endtask

    task automatic test_abs_set();
        abs_addr = 32'h000A_BCD0;
        op(3'd2, 1'b0);
        chk("R4", "ea", ea_q, 32'h000A_BCD0);
        chk("R4", "ptr", ptr_new_q, 32'h000A_BCD0);
        chk("R4", "wb", {31'd0, wb_en_q}, 32'h1);
    endtask

    task automatic test_post_reg();
        ptr_reg = 32'h0000_0100;
        mod_reg = 32'hFFFF_FFFC;
        op(3'd3, 1'b0);
        chk("R5", "ea", ea_q, 32'h0000_0100);
        chk("R5", "ptr", ptr_new_q, 32'h0000_00FC);
        chk("R10", "wb post", {31'd0, wb_en_q}, 32'h1);
    endtask

    task automatic test_brev();
        logic [31:0] exp_ofs [4] = '{32'd0, 32'd4, 32'd2, 32'd6};
        ptr_reg = 32'h0001_0000;
        mod_reg = 32'h0000_2000;
        for (int i = 0; i < 4; i++) begin
            op(3'd4, 1'b0);
            chk("R6", "brev ea", ea_q, 32'h0001_0000 + exp_ofs[i]);
            chk("R6", "brev ptr", ptr_new_q, 32'h0001_0000 + 32'h2000 * (i + 1));
            ptr_reg = ptr_new_q;
        end
    endtask

    task automatic test_post_imm();
        ptr_reg = 32'h0000_0200;
        imm_inc = 4'h8;
        op(3'd5, 1'b1);
        chk("R7", "half -8", ptr_new_q, 32'h0000_01F0);
        chk("R7", "ea", ea_q, 32'h0000_0200);
        imm_inc = 4'h7;
        op(3'd5, 1'b0);
        chk("R7", "byte +7", ptr_new_q, 32'h0000_0207);
    endtask

    task automatic test_circ_imm();
        circ_start = 32'h0000_3000;
        mod_reg    = 32'd4;
        ptr_reg    = 32'h0000_3000;
        imm_inc    = 4'h1;
        for (int i = 1; i <= 4; i++) begin
            op(3'd6, 1'b0);
            chk("R8", "fwd wrap", ptr_new_q, 32'h0000_3000 + (i % 4));
            ptr_reg = ptr_new_q;
        end
        ptr_reg = 32'h0000_3000;
        imm_inc = 4'hF;
        op(3'd6, 1'b0);
        chk("R8", "back wrap", ptr_new_q, 32'h0000_3003);
        ptr_reg = 32'h0000_3002;
        imm_inc = 4'h1;
        op(3'd6, 1'b1);
        chk("R8", "half wrap", ptr_new_q, 32'h0000_3000);
    endtask

    task automatic test_circ_reg();
        circ_start = 32'h0000_3000;
        mod_reg    = 32'h0002_0004;
        ptr_reg    = 32'h0000_3000;
        op(3'd7, 1'b1);
        chk("R9", "half step", ptr_new_q, 32'h0000_3002);
        ptr_reg = ptr_new_q;
        op(3'd7, 1'b1);
        chk("R9", "half wrap", ptr_new_q, 32'h0000_3000);
        mod_reg = 32'h00FE_0004;
        ptr_reg = 32'h0000_3000;
        op(3'd7, 1'b0);
        chk("R9", "neg field", ptr_new_q, 32'h0000_3003);
        chk("R9", "ea", ea_q, 32'h0000_3000);
    endtask

    task automatic test_latency();
        abs_addr = 32'h0000_5555;
        @(negedge clk);
        mode = 3'd2;
        #1;
        chk("R11", "holds before edge", ea_q, 32'h0000_3000);
        step();
        chk("R11", "after edge", ea_q, 32'h0000_5555);
    endtask

    initial begin
        rst_n = 1'b0;
        mode = 3'd0; size_half = 1'b0;
        base_reg = '0; index_reg = '0; abs_addr = '0; ptr_reg = '0;
        mod_reg = '0; circ_start = '0; idx_shift = '0; imm_ofs = '0; imm_inc = '0;
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_base_ofs();
        test_idx_abs();
        test_abs_set();
        test_post_reg();
        test_brev();
        test_post_imm();
        test_circ_imm();
        test_circ_reg();
        test_latency();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule